// File: doc/BRIEF.md
# Configurable Four-Macrocell Logic Tile

A programmable logic tile whose behaviour is fixed by a static configuration vector presented on parallel ports. Eighteen routed inputs feed an AND array of product terms. Twenty of them are logic terms that feed four macrocells through three selectable paths. Each path can use a short group of four terms, a single term XORed with three others, or the OR of all twenty terms. Three more terms are control terms. They supply a locally built clock, an asynchronous clear and an output-enable.

Each macrocell applies a polarity inversion and then drives its output either straight from the logic or from a D register. All four registers share one clock chosen for the whole tile: one of three global clock lines or the clock product term. Registers clear asynchronously from the active-low global clear or from the clear product term. The outputs leave the tile both toward pins, qualified by the output-enable, and toward the routing fabric as feedback. The fabric, configuration loading and pin routing lie outside the tile.

Top module: `logic_tile`

## Requirements
- R1: Product term p occupies `cfg_and[36p +: 36]`; bits [2i+1:2i] of that slice control input i: 2'b01 needs the input high, 2'b10 needs it low, 2'b11 accepts either level, 2'b00 leaves the input unconnected. A term with every input unconnected evaluates to 0. Terms 0..19 are logic terms, term 20 is the clock term, term 21 the clear term, term 22 the output-enable term.
- R2: With `cfg_path[2m+1:2m]` = 2'b00, macrocell m computes the OR of terms 4m..4m+3.
- R3: With path 2'b01, macrocell m computes term 4m XOR (OR of terms 4m+1..4m+3).
- R4: With path 2'b10 or 2'b11, macrocell m computes the OR of all twenty logic terms.
- R5: With `cfg_reg[m]`=0 the output follows the logic without delay. With `cfg_reg[m]`=1 the output shows the register, which loads the logic value on a rising edge of the selected clock and holds it otherwise.
- R6: `cfg_clk_sel` values 0, 1 and 2 select `gclk[0]`, `gclk[1]` and `gclk[2]`; value 3 selects the clock term. Edges on unselected clocks do not change the registers.
- R7: `gclr_n` low clears all registers at once, without waiting for a clock edge.
- R8: A high clear term clears all registers at once and keeps them clear across clock edges for as long as it stays high.
- R9: `mc_oe` equals the output-enable term.
- R10: `cfg_pol[m]`=1 inverts macrocell m's logic value before the register/combinational choice.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| gclk | input | 3 | Global clock lines |
| gclr_n | input | 1 | Global clear, active low, asynchronous |
| din | input | 18 | Routed inputs to the AND array |
| cfg_and | input | 828 | AND array programming, 36 bits per term |
| cfg_path | input | 8 | Path select, two bits per macrocell |
| cfg_pol | input | 4 | Output inversion per macrocell |
| cfg_reg | input | 4 | 1 = registered output, per macrocell |
| cfg_clk_sel | input | 2 | Tile clock source |
| mc_out | output | 4 | Macrocell outputs, also the feedback to the fabric |
| mc_oe | output | 1 | Output-enable from the enable term |

## Verification
The clear term and a rising edge of the selected clock can meet in the same cycle. That cycle decides whether the asynchronous clear wins over a load. The bench raises the clear term while the register's logic input is 1 and holds it across a global clock edge. It expects the registered output to read 0 before and after that edge. Once the clear is released, it expects the output to stay 0 until the next edge and then load the 1.

// File: rtl/logic_tile.sv
module logic_tile #(
  parameter int N_IN      = 18,
  parameter int N_MC      = 4,
  parameter int PT_PER_MC = 4,
  parameter int N_LPT     = 20,
  parameter int N_CLK     = 3
) (
  input  logic [N_CLK-1:0]                         gclk,
  input  logic                                     gclr_n,
  input  logic [N_IN-1:0]                          din,
  input  logic [(N_LPT+3)*2*N_IN-1:0]              cfg_and,
  input  logic [2*N_MC-1:0]                        cfg_path,
  input  logic [N_MC-1:0]                          cfg_pol,
  input  logic [N_MC-1:0]                          cfg_reg,
  input  logic [$clog2(N_CLK+1)-1:0]               cfg_clk_sel,
  output logic [N_MC-1:0]                          mc_out,
  output logic                                     mc_oe
);
  localparam int PTW    = 2 * N_IN;
  localparam int N_PT   = N_LPT + 3;
  localparam int PT_CLK = N_LPT;
  localparam int PT_RST = N_LPT + 1;
  localparam int PT_OE  = N_LPT + 2;

  logic [N_PT-1:0]  pt;
  logic [N_MC-1:0]  d;
  logic [N_MC-1:0]  q;
  logic [N_CLK:0]   clk_src;
  logic             pt_clk, pt_rst, rst_any, clk_mux;

  for (genvar p = 0; p < N_PT; p++) begin : g_pt
    logic [PTW-1:0]  c;
    logic [N_IN-1:0] hit;
    assign c = cfg_and[p*PTW +: PTW];
    for (genvar i = 0; i < N_IN; i++) begin : g_in
      assign hit[i] = (c[2*i] & c[2*i+1]) | (~c[2*i] & ~c[2*i+1]) |
                      (c[2*i] & din[i]) | (c[2*i+1] & ~din[i]);
    end
    assign pt[p] = (|c) & (&hit);
  end

  assign pt_clk  = pt[PT_CLK];
  assign pt_rst  = pt[PT_RST];
  assign mc_oe   = pt[PT_OE];
  assign rst_any = ~gclr_n | pt_rst;
  assign clk_src = {pt_clk, gclk};
  assign clk_mux = clk_src[cfg_clk_sel];

  for (genvar m = 0; m < N_MC; m++) begin : g_mc
    logic grp, rest, sum, q_r;
    assign grp  = |pt[m*PT_PER_MC +: PT_PER_MC];
    assign rest = |pt[m*PT_PER_MC+1 +: PT_PER_MC-1];

    always_comb begin
      case (cfg_path[2*m +: 2])
        2'b00:   sum = grp;
        2'b01:   sum = pt[m*PT_PER_MC] ^ rest;
        default: sum = |pt[N_LPT-1:0];
      endcase
    end

    assign d[m] = sum ^ cfg_pol[m];

    always_ff @(posedge clk_mux or posedge rst_any) begin
      if (rst_any) q_r <= 1'b0;
      else         q_r <= d[m];
    end

    assign q[m]      = q_r;
    assign mc_out[m] = cfg_reg[m] ? q_r : d[m];
  end
endmodule

// File: rtl/logic_tile_chk.sv
module logic_tile_chk #(
  parameter int N_MC  = 4,
  parameter int N_CLK = 3
) (
  input logic [N_CLK-1:0]             gclk,
  input logic                         gclr_n,
  input logic [$clog2(N_CLK+1)-1:0]   cfg_clk_sel,
  input logic [N_MC-1:0]              q,
  input logic [N_MC-1:0]              d,
  input logic                         pt_clk,
  input logic                         pt_rst,
  input logic                         rst_any
);
  localparam int SELW = $clog2(N_CLK + 1);

  always @(posedge gclk[0]) begin
    if (!gclr_n) p_gclr_clears_r7: assert (q == '0);
    if (pt_rst)  p_ptrst_clears_r8: assert (q == '0);
  end

  p_load_on_edge_r5: assert property (@(posedge gclk[0]) disable iff (!gclr_n)
    (cfg_clk_sel == SELW'(0) && !rst_any) |=>
    (cfg_clk_sel != SELW'(0) || rst_any || q == $past(d)));

  p_g1_hold_r6: assert property (@(posedge gclk[0]) disable iff (!gclr_n)
    (cfg_clk_sel == SELW'(1) && !gclk[1] && !rst_any) |=>
    (gclk[1] || rst_any || $stable(q)));

  p_ptclk_hold_r6: assert property (@(posedge gclk[0]) disable iff (!gclr_n)
    (cfg_clk_sel == SELW'(3) && !pt_clk && !rst_any) |=>
    (pt_clk || rst_any || $stable(q)));
endmodule

bind logic_tile logic_tile_chk #(.N_MC(N_MC), .N_CLK(N_CLK)) u_chk (
  .gclk(gclk), .gclr_n(gclr_n), .cfg_clk_sel(cfg_clk_sel), .q(q), .d(d),
  .pt_clk(pt_clk), .pt_rst(pt_rst), .rst_any(rst_any)
);

// File: tb/logic_tile_test.sv
module logic_tile_test;
  localparam int CLK_PERIOD = 10;
  localparam int N_IN = 18;
  localparam int PTW  = 36;
  localparam int N_PT = 23;

  // {din[9:0], expected mc_out[2:0]}
  localparam logic [12:0] VEC [10] = '{
    13'h0001, 13'h0024, 13'h0039, 13'h0062, 13'h00E0,
    13'h0124, 13'h0320, 13'h00A2, 13'h1020, 13'h002C
  };

  logic                  clk = 1'b0, g1 = 1'b0, g2 = 1'b0;
  logic                  gclr_n;
  logic [N_IN-1:0]       din;
  logic [N_PT*PTW-1:0]   cfg_and;
  logic [7:0]            cfg_path;
  logic [3:0]            cfg_pol, cfg_reg;
  logic [1:0]            cfg_clk_sel;
  logic [3:0]            mc_out;
  logic                  mc_oe;
  int                    checks = 0, fails = 0;
  bit                    done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  logic_tile uut (
    .gclk({g2, g1, clk}), .gclr_n(gclr_n), .din(din), .cfg_and(cfg_and),
    .cfg_path(cfg_path), .cfg_pol(cfg_pol), .cfg_reg(cfg_reg),
    .cfg_clk_sel(cfg_clk_sel), .mc_out(mc_out), .mc_oe(mc_oe)
  );

  task automatic chk(input string tag, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic pt_set(input int p, input int i, input logic [1:0] code);
    cfg_and[p*PTW + 2*i +: 2] = code;
  endtask

  task automatic step(input logic [N_IN-1:0] v);
    @(negedge clk);
    din = v;
    #1;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL R5 watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    gclr_n = 1'b0; din = '0; cfg_and = '0; cfg_path = '0;
    cfg_pol = '0; cfg_reg = 4'b1000; cfg_clk_sel = 2'd0;
    @(negedge clk); @(negedge clk); #1;
    chk("R7 reset state", mc_out, 4'b0000);
    chk("R1 unprogrammed terms are 0", {3'b0, mc_oe}, 4'b0000);

    pt_set(0, 0, 2'b01); pt_set(0, 1, 2'b01);
    pt_set(1, 2, 2'b10);
    pt_set(4, 3, 2'b01); pt_set(5, 4, 2'b01);
    pt_set(8, 5, 2'b01); pt_set(8, 6, 2'b01); pt_set(9, 7, 2'b01);
    pt_set(12, 8, 2'b01); pt_set(16, 9, 2'b01);
    pt_set(20, 10, 2'b01); pt_set(21, 11, 2'b01);
    pt_set(22, 12, 2'b01); pt_set(22, 13, 2'b01);
    cfg_path = 8'b00_10_01_00;
    cfg_pol  = 4'b0100;
    @(negedge clk);
    gclr_n = 1'b1;

    for (int k = 0; k < 10; k++) begin
      step({8'b0, VEC[k][12:3]});
      chk("R1/R2/R3/R4/R10 table", {1'b0, mc_out[2:0]}, {1'b0, VEC[k][2:0]});
    end

    step(18'h00004);
    pt_set(2, 15, 2'b11); #1;
    chk("R1 either-level term", {3'b0, mc_out[0]}, 4'b0001);
    pt_set(2, 15, 2'b00); #1;
    cfg_pol[0] = 1'b1; #1;
    chk("R10 inversion", {3'b0, mc_out[0]}, 4'b0001);
    cfg_pol[0] = 1'b0;

    step(18'h00100);
    chk("R5 hold before edge", {3'b0, mc_out[3]}, 4'b0000);
    step(18'h00000);
    chk("R5 load on gclk0 edge", {3'b0, mc_out[3]}, 4'b0001);
    step(18'h00000);
    chk("R5 load 0", {3'b0, mc_out[3]}, 4'b0000);
    cfg_reg[3] = 1'b0;
    step(18'h00100);
    chk("R5 combinational", {3'b0, mc_out[3]}, 4'b0001);
    step(18'h00000);
    cfg_reg[3] = 1'b1;

    @(negedge clk); cfg_clk_sel = 2'd1;
    step(18'h00100); step(18'h00100); step(18'h00100);
    chk("R6 gclk0 ignored", {3'b0, mc_out[3]}, 4'b0000);
    g1 = 1'b1; #1;
    chk("R6 load on gclk1", {3'b0, mc_out[3]}, 4'b0001);
    @(negedge clk); g1 = 1'b0;
    cfg_clk_sel = 2'd2;
    step(18'h00000); step(18'h00000);
    chk("R6 gclk2 not yet", {3'b0, mc_out[3]}, 4'b0001);
    g2 = 1'b1; #1;
    chk("R6 load on gclk2", {3'b0, mc_out[3]}, 4'b0000);
    @(negedge clk); g2 = 1'b0;

    cfg_clk_sel = 2'd3;
    step(18'h00100); step(18'h00100);
    chk("R6 clock term idle", {3'b0, mc_out[3]}, 4'b0000);
    step(18'h00500);
    chk("R6 load on clock term", {3'b0, mc_out[3]}, 4'b0001);
    step(18'h00100);
    @(negedge clk); cfg_clk_sel = 2'd0;

    step(18'h00900);
    chk("R8 clear term immediate", {3'b0, mc_out[3]}, 4'b0000);
    step(18'h00900);
    chk("R8 clear beats clock edge", {3'b0, mc_out[3]}, 4'b0000);
    step(18'h00100);
    chk("R8 released, no edge yet", {3'b0, mc_out[3]}, 4'b0000);
    step(18'h00100);
    chk("R8 load after release", {3'b0, mc_out[3]}, 4'b0001);

    @(negedge clk); gclr_n = 1'b0; #1;
    chk("R7 global clear immediate", {3'b0, mc_out[3]}, 4'b0000);
    step(18'h00100);
    chk("R7 global clear held", {3'b0, mc_out[3]}, 4'b0000);
    @(negedge clk); gclr_n = 1'b1;

    step(18'h01000);
    chk("R9 enable term partial", {3'b0, mc_oe}, 4'b0000);
    step(18'h03000);
    chk("R9 enable term full", {3'b0, mc_oe}, 4'b0001);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule